// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the iterative integer multiply and divide engine of a 32-bit processor core. It holds the dedicated 64-bit result pair, split into a high word (HI) and a low word (LO). The pipeline sends it one request per cycle. Each request is a six-bit function code with two operands. Arithmetic requests start a multicycle operation. Move requests read or write one half of the pair directly.

Signed and unsigned multiply write the full 64-bit product across HI:LO. Signed and unsigned divide write the quotient to LO and the remainder to HI. Signed and unsigned variants share a single shift-add / restoring-division datapath. Operands are converted to magnitudes on entry, and the sign is fixed on the final step. While an operation runs, `busy` is high. Reads of HI or LO are held off by a low `rd_ready`, so the pipeline stalls until the result is in place.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset `busy` is low and both HI and LO read as zero.
- R2: Function code 0x18 multiplies the operands as two's-complement numbers and writes the 64-bit product, upper half to HI and lower half to LO.
- R3: Function code 0x19 multiplies the operands as unsigned numbers and writes the 64-bit product, upper half to HI and lower half to LO.
- R4: Function code 0x1A divides `src_a` by `src_b` as signed numbers. The quotient truncates toward zero and goes to LO. The remainder takes the sign of the dividend and goes to HI. The most negative value divided by -1 gives LO = 0x80000000 and HI = 0.
- R5: Function code 0x1B divides `src_a` by `src_b` as unsigned numbers, writing the quotient to LO and the remainder to HI.
- R6: Division by zero, signed or unsigned, takes the normal time. It leaves LO = 0xFFFFFFFF and HI equal to `src_a`, with no error indication.
- R7: An arithmetic request accepted while idle raises `busy` from the next cycle for exactly 32 cycles. The new HI/LO values are readable in the first cycle `busy` is low again.
- R8: Function codes 0x10 (read HI) and 0x12 (read LO) drive `rd_ready` high and `rd_data` with the register in the same cycle when `busy` is low. While `busy` is high, `rd_ready` stays low.
- R9: Function codes 0x11 and 0x13 load `src_a` into HI or LO respectively, visible from the next cycle. `src_b` has no effect.
- R10: While `busy` is high, every request other than a read is ignored. HI and LO keep their values and the running operation is neither restarted nor lengthened.
- R11: A request with a function code outside the eight listed above changes neither HI, LO nor `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_func | input | 6 | Function code of the request |
| src_a | input | 32 | First operand (multiplicand, dividend or move source) |
| src_b | input | 32 | Second operand (multiplier or divisor) |
| busy | output | 1 | Multicycle operation in progress |
| rd_ready | output | 1 | Read request answered this cycle |
| rd_data | output | 32 | HI or LO value for a read request |

## Verification
The bench targets several boundary cases:
- Signed operand pairs with every sign combination, including the most negative value times itself and divided by -1. A missing or misplaced sign fix-up shows up as a wrong product or quotient sign.
- Division by zero with a negative dividend. A design that applies the quotient sign rule there returns 1 instead of all ones in LO.
- All-ones unsigned operands, which expose a lost carry in the shift-add accumulator.

During every operation the bench tries reads, move writes and new arithmetic requests. A unit that leaks any of these would answer a read early, change HI/LO mid-operation, or stretch `busy` beyond 32 cycles.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [5:0] {
    FN_MFHI  = 6'h10,
    FN_MTHI  = 6'h11,
    FN_MFLO  = 6'h12,
    FN_MTLO  = 6'h13,
    FN_MULT  = 6'h18,
    FN_MULTU = 6'h19,
    FN_DIV   = 6'h1A,
    FN_DIVU  = 6'h1B
  } md_func_e;

  typedef struct packed {
    logic is_div;
    logic is_signed;
  } md_mode_t;

  function automatic logic fn_is_arith(input logic [5:0] f);
    return (f == FN_MULT) || (f == FN_MULTU) || (f == FN_DIV) || (f == FN_DIVU);
  endfunction

  function automatic logic fn_is_read(input logic [5:0] f);
    return (f == FN_MFHI) || (f == FN_MFLO);
  endfunction

  // bit 1 separates divide from multiply, bit 0 marks the unsigned variant
  function automatic md_mode_t fn_mode(input logic [5:0] f);
    md_mode_t m;
    m.is_div    = f[1];
    m.is_signed = ~f[0];
    return m;
  endfunction

endpackage

// File: rtl/md_sequencer.sv
module md_sequencer #(
  parameter int STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [CW-1:0] step_q;

  assign last = busy && (step_q == CW'(STEPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      step_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      step_q <= '0;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      step_q <= step_q + 1'b1;
    end
  end
endmodule

// File: rtl/md_datapath.sv
module md_datapath
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           step_en,
  input  md_mode_t       mode,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  output logic [W-1:0]   res_hi,
  output logic [W-1:0]   res_lo
);
  localparam int WW = 2 * W;

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] x, input logic sgn);
    return (sgn && x[W-1]) ? -x : x;
  endfunction

  // one shift-add step: upper half accumulates, multiplier shifts out at bit 0
  function automatic logic [WW-1:0] mul_step(input logic [WW-1:0] wk, input logic [W-1:0] m);
    logic [W:0] sum;
    sum = {1'b0, wk[WW-1:W]} + (wk[0] ? {1'b0, m} : {(W+1){1'b0}});
    return {sum, wk[W-1:1]};
  endfunction

  // one restoring step: upper half is the partial remainder, lower half the quotient
  function automatic logic [WW-1:0] div_step(input logic [WW-1:0] wk, input logic [W-1:0] d);
    logic [WW:0] sh;
    logic [W:0]  diff;
    sh   = {wk, 1'b0};
    diff = sh[WW:W] - {1'b0, d};
    if (!diff[W]) return {diff[W-1:0], sh[W-1:1], 1'b1};
    return {sh[WW-1:W], sh[W-1:1], 1'b0};
  endfunction

  logic [WW-1:0] work_q, work_nxt, prod;
  logic [W-1:0]  opnd_q, quo, rem;
  md_mode_t      mode_q;
  logic          neg_a_q, neg_b_q, bzero_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work_q  <= '0;
      opnd_q  <= '0;
      mode_q  <= '0;
      neg_a_q <= 1'b0;
      neg_b_q <= 1'b0;
      bzero_q <= 1'b0;
    end else if (start) begin
      work_q  <= {{W{1'b0}}, magnitude(opa, mode.is_signed)};
      opnd_q  <= magnitude(opb, mode.is_signed);
      mode_q  <= mode;
      neg_a_q <= mode.is_signed & opa[W-1];
      neg_b_q <= mode.is_signed & opb[W-1];
      bzero_q <= (opb == '0);
    end else if (step_en) begin
      work_q  <= work_nxt;
    end
  end

  always_comb begin
    work_nxt = mode_q.is_div ? div_step(work_q, opnd_q) : mul_step(work_q, opnd_q);
    prod = (neg_a_q ^ neg_b_q) ? -work_nxt : work_nxt;
    quo  = ((neg_a_q ^ neg_b_q) && !bzero_q) ? -work_nxt[W-1:0] : work_nxt[W-1:0];
    rem  = neg_a_q ? -work_nxt[WW-1:W] : work_nxt[WW-1:W];
    if (mode_q.is_div) begin
      res_hi = rem;
      res_lo = quo;
    end else begin
      res_hi = prod[WW-1:W];
      res_lo = prod[W-1:0];
    end
  end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [5:0]   req_func,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic         busy,
  output logic         rd_ready,
  output logic [W-1:0] rd_data
);
  logic         start_op, finish_op, idle_req;
  logic         wr_hi, wr_lo;
  logic [W-1:0] hi_q, lo_q, res_hi, res_lo;

  assign idle_req  = req_valid && !busy;
  assign start_op  = idle_req && fn_is_arith(req_func);
  assign wr_hi     = idle_req && (req_func == FN_MTHI);
  assign wr_lo     = idle_req && (req_func == FN_MTLO);
  assign rd_ready  = idle_req && fn_is_read(req_func);
  assign rd_data   = (req_func == FN_MFHI) ? hi_q : lo_q;

  md_sequencer #(.STEPS(W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_op),
    .busy  (busy),
    .last  (finish_op)
  );

  md_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_op),
    .step_en (busy),
    .mode    (fn_mode(req_func)),
    .opa     (src_a),
    .opb     (src_b),
    .res_hi  (res_hi),
    .res_lo  (res_lo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (finish_op) begin
      hi_q <= res_hi;
      lo_q <= res_lo;
    end else begin
      if (wr_hi) hi_q <= src_a;
      if (wr_lo) lo_q <= src_a;
    end
  end
endmodule

// File: rtl/md_hilo_checker.sv
module md_hilo_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic [5:0]   req_func,
  input logic [W-1:0] src_a,
  input logic         busy,
  input logic         rd_ready,
  input logic         start_op,
  input logic         finish_op,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  a_r7_busy_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_op |=> busy);

  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_len < W - 1) |=> busy);

  a_r7_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_len == W - 1) |=> !busy);

  a_r7_finish_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    finish_op |-> (busy && run_len == W - 1));

  a_r8_no_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_ready);

  a_r10_hilo_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish_op) |=> ($stable(hi_q) && $stable(lo_q)));

  a_r9_move_to_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_func == 6'h11) |=> (hi_q == $past(src_a)));

  a_r9_move_to_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_func == 6'h13) |=> (lo_q == $past(src_a)));
endmodule

bind muldiv_hilo md_hilo_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_func  (req_func),
  .src_a     (src_a),
  .busy      (busy),
  .rd_ready  (rd_ready),
  .start_op  (start_op),
  .finish_op (finish_op),
  .hi_q      (hi_q),
  .lo_q      (lo_q)
);

// File: tb/muldiv_hilo_bench.sv
`timescale 1ns/1ps
module muldiv_hilo_bench;
  localparam logic [5:0] F_MFHI = 6'h10, F_MTHI = 6'h11, F_MFLO = 6'h12, F_MTLO = 6'h13;
  localparam logic [5:0] F_MULT = 6'h18, F_MULTU = 6'h19, F_DIV = 6'h1A, F_DIVU = 6'h1B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_func = 6'h0;
  logic [31:0] src_a = '0, src_b = '0;
  logic        busy, rd_ready;
  logic [31:0] rd_data;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] m_hi = '0, m_lo = '0, p_hi = '0, p_lo = '0;
  int m_busy = 0;

  always #10 clk = ~clk;

  muldiv_hilo u_muldiv_hilo (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_func(req_func),
    .src_a(src_a), .src_b(src_b), .busy(busy), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  task automatic reference(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                           output logic [31:0] hi, output logic [31:0] lo);
    longint s, t, r;
    longint unsigned u, v, w;
    hi = '0; lo = '0;
    case (f)
      F_MULT: begin
        s = longint'(int'(a)); t = longint'(int'(b)); r = s * t;
        hi = r[63:32]; lo = r[31:0];
      end
      F_MULTU: begin
        u = a; v = b; w = u * v;
        hi = w[63:32]; lo = w[31:0];
      end
      F_DIV: begin
        if (b == 0) begin hi = a; lo = 32'hFFFF_FFFF; end
        else begin
          s = longint'(int'(a)); t = longint'(int'(b));
          r = s / t; lo = r[31:0];
          r = s % t; hi = r[31:0];
        end
      end
      default: begin
        if (b == 0) begin hi = a; lo = 32'hFFFF_FFFF; end
        else begin
          u = a; v = b;
          w = u / v; lo = w[31:0];
          w = u % v; hi = w[31:0];
        end
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = '0; m_lo = '0; m_busy = 0;
    end else if (m_busy > 0) begin
      m_busy = m_busy - 1;
      if (m_busy == 0) begin m_hi = p_hi; m_lo = p_lo; end
    end else if (req_valid) begin
      if (req_func inside {F_MULT, F_MULTU, F_DIV, F_DIVU}) begin
        reference(req_func, src_a, src_b, p_hi, p_lo);
        m_busy = 32;
      end else if (req_func == F_MTHI) m_hi = src_a;
      else if (req_func == F_MTLO) m_lo = src_a;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one request, compare outputs against the model, advance one clock
  task automatic step(input logic v, input logic [5:0] f, input logic [31:0] a,
                      input logic [31:0] b, input string tag);
    req_valid = v; req_func = f; src_a = a; src_b = b;
    #1;
    check({"R7 busy ", tag}, {31'b0, busy}, {31'b0, m_busy != 0});
    if (v && (f == F_MFHI || f == F_MFLO)) begin
      check({"R8 ready ", tag}, {31'b0, rd_ready}, {31'b0, m_busy == 0});
      if (m_busy == 0)
        check({"R8 data ", tag}, rd_data, (f == F_MFHI) ? m_hi : m_lo);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_op(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                        input string tag);
    int n = 0;
    step(1'b1, f, a, b, tag);
    while (busy && n < 100) begin
      case (n % 4)
        0: step(1'b1, F_MFHI, '0, '0, {"R8 held ", tag});
        1: step(1'b1, F_MTHI, 32'hDEAD_BEEF, '0, {"R10 ", tag});
        2: step(1'b1, F_MULTU, 32'h1234_5678, 32'h9, {"R10 ", tag});
        default: step(1'b1, F_MFLO, '0, '0, {"R8 held ", tag});
      endcase
      n++;
    end
    check({"R7 length ", tag}, n, 32);
    step(1'b1, F_MFHI, '0, '0, tag);
    step(1'b1, F_MFLO, '0, '0, tag);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h8000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h0;
      3: return 32'h1;
      4: return 32'h7FFF_FFFF;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step(1'b1, F_MFHI, '0, '0, "R1 reset HI");
    step(1'b1, F_MFLO, '0, '0, "R1 reset LO");
    // R9 moves, src_b ignored
    step(1'b1, F_MTHI, 32'hA5A5_0001, 32'hFFFF_FFFF, "R9 mthi");
    step(1'b1, F_MTLO, 32'h0F0F_0002, 32'h1111_1111, "R9 mtlo");
    step(1'b1, F_MFHI, '0, '0, "R9 read HI");
    step(1'b1, F_MFLO, '0, '0, "R9 read LO");
    // R11 unknown codes
    step(1'b1, 6'h20, 32'h5, 32'h7, "R11 unknown");
    step(1'b1, 6'h1C, 32'h5, 32'h7, "R11 unknown");
    step(1'b0, F_MULT, 32'h5, 32'h7, "R11 idle");
    step(1'b1, F_MFHI, '0, '0, "R11 HI kept");
    step(1'b1, F_MFLO, '0, '0, "R11 LO kept");
    // R2 signed multiply
    run_op(F_MULT, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 -1*-1");
    run_op(F_MULT, 32'h8000_0000, 32'h8000_0000, "R2 min*min");
    run_op(F_MULT, 32'h8000_0000, 32'hFFFF_FFFF, "R2 min*-1");
    run_op(F_MULT, 32'h7FFF_FFFF, 32'hFFFF_FFFE, "R2 max*-2");
    // R3 unsigned multiply
    run_op(F_MULTU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 all ones");
    run_op(F_MULTU, 32'h8000_0000, 32'h2, "R3 carry");
    // R4 signed divide
    run_op(F_DIV, 32'd7, 32'hFFFF_FFFE, "R4 7/-2");
    run_op(F_DIV, 32'hFFFF_FFF9, 32'd2, "R4 -7/2");
    run_op(F_DIV, 32'h8000_0000, 32'hFFFF_FFFF, "R4 min/-1");
    run_op(F_DIV, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R4 -7/-2");
    // R5 unsigned divide
    run_op(F_DIVU, 32'hFFFF_FFFF, 32'd3, "R5 max/3");
    run_op(F_DIVU, 32'd5, 32'hFFFF_FFFF, "R5 small/big");
    // R6 divide by zero
    run_op(F_DIV, 32'hFFFF_FF00, 32'd0, "R6 signed neg/0");
    run_op(F_DIV, 32'd1234, 32'd0, "R6 signed pos/0");
    run_op(F_DIVU, 32'h8765_4321, 32'd0, "R6 unsigned/0");
    // mixed random operations, all four arithmetic codes
    for (int i = 0; i < 60; i++) begin
      logic [5:0] f;
      f = 6'h18 + 6'($urandom_range(0, 3));
      run_op(f, pick(), pick(), "R2 R3 R4 R5 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule